// File: doc/BRIEF.md
# Planar Write Datapath for a VGA-Style Graphics Controller

This block turns one CPU byte write into a set of per-plane byte writes toward a plane-interleaved video memory. The memory word at a base address holds up to eight bytes, one for each plane. The block combines the CPU byte with the controller's register values: rotate count and logic function, bit mask, set/reset colour and its per-plane enables, plane write mask, write mode, and the extended-mode flags. From these it produces a byte-enable vector, a 64-bit write word and a write address, all registered one clock after the strobe.

The block also holds the latch bytes that the logic functions and write mode 1 use. A CPU read loads them from the aligned word at the CPU address with its two low bits cleared, and also returns one byte of that word. Two extended colour-expansion modes write up to eight pixels from one CPU byte. These modes use a foreground and a background colour and a shifted, masked address. When the extended-write and address-by-8 flags are both set, the plane mask is applied bit-reversed in every write mode.

Top module: `vga_plane_writer`

## Requirements
- R1: After reset, `mem_we`, `mem_wdata`, `mem_addr`, `rd_data` and all latch bytes are zero.
- R2: In write modes 0 and 3 (`write_mode` 0 and 3), the CPU byte is rotated right by `rot_fn[2:0]` before it is used.
- R3: `rot_fn[4:3]` selects the function, with source s, mask m and latch l: 00 gives (s&m)|(l&~m), 01 gives (s|~m)&l, 10 gives (s&m)|l, 11 gives (s&m)^l. In modes 0 and 2, m is `bit_mask`.
- R4: In mode 0, plane i takes `{8{set_reset[i]}}` as its source when `sr_enable[i]` is 1, and the rotated byte otherwise. In mode 2, plane i takes `{8{cpu_data[i]}}` as its source.
- R5: In mode 1, each enabled plane is written with its latch byte unchanged.
- R6: In mode 3, the source of plane i is `{8{set_reset[i]}}` and the mask is `bit_mask` ANDed with the rotated CPU byte.
- R7: In modes 0 to 3, with `latch8` clear, only planes 0 to 3 can be enabled. With `latch8` set, planes 0 to 7 can be enabled.
- R8: In modes 0 to 3, plane i is enabled by `plane_mask[7-i]` when `ext_write` and `addr_by8` are both 1, and by `plane_mask[i]` otherwise.
- R9: `mem_addr` is the CPU address ANDed with `decode_mask`. In modes 4 and 5, the address is first shifted left by 2 if `expand_by4` is 1, and by 1 otherwise.
- R10: In mode 4, byte i is enabled when `cpu_data[7-i]` and `plane_mask[7-i]` are both 1, and is written with `fg_color`. In mode 5, byte i is enabled by `plane_mask[7-i]` and is written with `fg_color` when `cpu_data[7-i]` is 1 and with `bg_color` when it is 0.
- R11: `rd_addr` is `cpu_addr` with its two low bits cleared. On `rd_stb`, latch byte i is loaded from `mem_rdata[8i+7:8i]`, and on the next clock `rd_data` shows the byte that `cpu_addr[1:0]` selects.
- R12: The write outputs appear one clock after `wr_stb`. `mem_we` is zero after any cycle without `wr_stb`, and after a write whose `write_mode` is 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | CPU write strobe |
| rd_stb | input | 1 | CPU read strobe |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_data | input | 8 | CPU write data |
| rot_fn | input | 5 | Rotate count [2:0], function [4:3] |
| bit_mask | input | 8 | Bit mask |
| set_reset | input | 8 | Set/reset colour, one bit per plane |
| sr_enable | input | 8 | Set/reset enable, one bit per plane |
| plane_mask | input | 8 | Plane write mask |
| write_mode | input | 3 | Write mode 0..5 |
| ext_write | input | 1 | Extended-write flag |
| addr_by8 | input | 1 | Address-by-8 flag |
| latch8 | input | 1 | Eight planes/latches when 1, four when 0 |
| expand_by4 | input | 1 | Expansion address shift of 2 (1) or 1 (0) |
| decode_mask | input | ADDR_W | Address decode mask |
| fg_color | input | 8 | Expansion foreground |
| bg_color | input | 8 | Expansion background |
| mem_rdata | input | 64 | Memory word at rd_addr, byte i = plane i |
| rd_addr | output | ADDR_W | Aligned read address |
| rd_data | output | 8 | Registered read byte |
| mem_we | output | 8 | Registered per-plane byte enables |
| mem_wdata | output | 64 | Registered write word |
| mem_addr | output | ADDR_W | Registered write address |

## Verification
A latch byte that is wrong stays hidden until it is used. It shows at the ports on the first later write in mode 1, or on a write that uses a logic function with a partial bit mask, one clock after that strobe. A wrong plane-enable order, plane count or expansion decode shows on `mem_we` one clock after the strobe that triggers it. The bench therefore follows every read with a mode 1 write. It also drives the bit-reversal and four-plane flags across all write modes, so a fault appears on the very next write.

// File: rtl/vga_plane_writer.sv
module vga_plane_writer #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic [4:0]        rot_fn,
  input  logic [7:0]        bit_mask,
  input  logic [7:0]        set_reset,
  input  logic [7:0]        sr_enable,
  input  logic [7:0]        plane_mask,
  input  logic [2:0]        write_mode,
  input  logic              ext_write,
  input  logic              addr_by8,
  input  logic              latch8,
  input  logic              expand_by4,
  input  logic [ADDR_W-1:0] decode_mask,
  input  logic [7:0]        fg_color,
  input  logic [7:0]        bg_color,
  input  logic [63:0]       mem_rdata,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [7:0]        mem_we,
  output logic [63:0]       mem_wdata,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int NB = 8;
  localparam int DW = NB * 8;

  logic [DW-1:0] latch_q;
  logic [NB-1:0] we_c;
  logic [DW-1:0] wd_c;

  wire [2:0] rot = rot_fn[2:0];
  wire [1:0] fn  = rot_fn[4:3];
  wire [3:0] rot_l = 4'd8 - {1'b0, rot};
  wire [7:0] rot_d = (cpu_data >> rot) | (cpu_data << rot_l);
  wire       rev = ext_write & addr_by8;
  wire       xmode = (write_mode == 3'd4) || (write_mode == 3'd5);
  wire [7:0] eff_mask = (write_mode == 3'd3) ? (bit_mask & rot_d) : bit_mask;
  wire [ADDR_W-1:0] sh_addr = !xmode ? cpu_addr :
                              expand_by4 ? (cpu_addr << 2) : (cpu_addr << 1);

  assign rd_addr = {cpu_addr[ADDR_W-1:2], 2'b00};

  for (genvar g = 0; g < NB; g++) begin : g_plane
    wire       lane_ok = (g < 4) ? 1'b1 : latch8;
    wire       pen  = (rev ? plane_mask[NB-1-g] : plane_mask[g]) & lane_ok;
    wire       xbit = cpu_data[NB-1-g];
    wire       xmsk = plane_mask[NB-1-g];
    wire [7:0] lat  = latch_q[g*8 +: 8];
    logic [7:0] src, res;

    always_comb begin
      case (write_mode)
        3'd0:    src = sr_enable[g] ? {8{set_reset[g]}} : rot_d;
        3'd2:    src = {8{cpu_data[g]}};
        default: src = {8{set_reset[g]}};
      endcase
      case (fn)
        2'd0:    res = (src & eff_mask) | (lat & ~eff_mask);
        2'd1:    res = (src | ~eff_mask) & lat;
        2'd2:    res = (src & eff_mask) | lat;
        default: res = (src & eff_mask) ^ lat;
      endcase
    end

    always_comb begin
      case (write_mode)
        3'd0, 3'd2, 3'd3: begin we_c[g] = pen;         wd_c[g*8 +: 8] = res; end
        3'd1:             begin we_c[g] = pen;         wd_c[g*8 +: 8] = lat; end
        3'd4:             begin we_c[g] = xbit & xmsk; wd_c[g*8 +: 8] = fg_color; end
        3'd5:             begin we_c[g] = xmsk;        wd_c[g*8 +: 8] = xbit ? fg_color : bg_color; end
        default:          begin we_c[g] = 1'b0;        wd_c[g*8 +: 8] = 8'h00; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= '0;
      mem_wdata <= '0;
      mem_addr  <= '0;
      latch_q   <= '0;
      rd_data   <= '0;
    end else begin
      mem_we <= wr_stb ? we_c : '0;
      if (wr_stb) begin
        mem_wdata <= wd_c;
        mem_addr  <= sh_addr & decode_mask;
      end
      if (rd_stb) begin
        latch_q <= mem_rdata;
        rd_data <= mem_rdata[cpu_addr[1:0]*8 +: 8];
      end
    end
  end
endmodule

module vga_plane_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_stb,
  input logic        rd_stb,
  input logic [2:0]  write_mode,
  input logic        latch8,
  input logic [7:0]  cpu_data,
  input logic [7:0]  plane_mask,
  input logic [7:0]  mem_we,
  input logic [63:0] mem_wdata,
  input logic [63:0] latch_q
);
  logic [7:0] rev_dm;
  for (genvar g = 0; g < 8; g++) begin : g_rev
    assign rev_dm[g] = cpu_data[7-g] & plane_mask[7-g];
  end

  AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> mem_we == 8'h00); // R12
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && write_mode > 3'd5) |=> mem_we == 8'h00); // R12
  AST_FOUR_PLANES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && write_mode < 3'd4 && !latch8) |=> mem_we[7:4] == 4'h0); // R7
  AST_EXPAND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && write_mode == 3'd4) |=> (mem_we & ~$past(rev_dm)) == 8'h00); // R10
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(latch_q)); // R11
  AST_COPY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && write_mode == 3'd1) |=> mem_wdata == $past(latch_q)); // R5
endmodule

bind vga_plane_writer vga_plane_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .write_mode(write_mode), .latch8(latch8), .cpu_data(cpu_data),
  .plane_mask(plane_mask), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .latch_q(latch_q)
);

// File: tb/tb_vga_plane_writer.sv
`timescale 1ns/1ps
module tb_vga_plane_writer;
  localparam int ADDR_W = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_stb = 0, rd_stb = 0;
  logic [ADDR_W-1:0] cpu_addr = '0, decode_mask = '1;
  logic [7:0] cpu_data = 0, bit_mask = 0, set_reset = 0, sr_enable = 0, plane_mask = 0;
  logic [7:0] fg_color = 0, bg_color = 0;
  logic [4:0] rot_fn = 0;
  logic [2:0] write_mode = 0;
  logic ext_write = 0, addr_by8 = 0, latch8 = 0, expand_by4 = 0;
  logic [63:0] mem_rdata = 0;
  logic [ADDR_W-1:0] rd_addr, mem_addr;
  logic [7:0] rd_data, mem_we;
  logic [63:0] mem_wdata;

  logic [7:0] lt [8];
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vga_plane_writer #(.ADDR_W(ADDR_W)) dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ror8(logic [7:0] v, int n);
    logic [7:0] r = v;
    for (int k = 0; k < n; k++) r = {r[0], r[7:1]};
    return r;
  endfunction

  function automatic logic [7:0] fn_apply(logic [1:0] f, logic [7:0] s, logic [7:0] m, logic [7:0] l);
    case (f)
      2'd0: return (s & m) | (l & ~m);
      2'd1: return (s | ~m) & l;
      2'd2: return (s & m) | l;
      default: return (s & m) ^ l;
    endcase
  endfunction

  task automatic model(output logic [7:0] we, output logic [63:0] wd, output logic [ADDR_W-1:0] ad);
    logic [7:0] d, m, s;
    int np;
    d = ror8(cpu_data, rot_fn[2:0]);
    np = latch8 ? 8 : 4;
    we = 0; wd = 0;
    for (int i = 0; i < 8; i++) begin
      logic pe;
      pe = (i < np) && ((ext_write && addr_by8) ? plane_mask[7-i] : plane_mask[i]);
      case (write_mode)
        3'd0, 3'd2, 3'd3: begin
          m = (write_mode == 3) ? (bit_mask & d) : bit_mask;
          if (write_mode == 0) s = sr_enable[i] ? {8{set_reset[i]}} : d;
          else if (write_mode == 2) s = {8{cpu_data[i]}};
          else s = {8{set_reset[i]}};
          we[i] = pe; wd[i*8 +: 8] = fn_apply(rot_fn[4:3], s, m, lt[i]);
        end
        3'd1: begin we[i] = pe; wd[i*8 +: 8] = lt[i]; end
        3'd4: begin we[i] = cpu_data[7-i] & plane_mask[7-i]; wd[i*8 +: 8] = fg_color; end
        3'd5: begin we[i] = plane_mask[7-i]; wd[i*8 +: 8] = cpu_data[7-i] ? fg_color : bg_color; end
        default: we[i] = 0;
      endcase
    end
    if (write_mode == 4 || write_mode == 5)
      ad = (expand_by4 ? (cpu_addr << 2) : (cpu_addr << 1)) & decode_mask;
    else
      ad = cpu_addr & decode_mask;
  endtask

  function automatic logic [63:0] byte_mask(logic [7:0] we);
    logic [63:0] r = 0;
    for (int i = 0; i < 8; i++) if (we[i]) r[i*8 +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic do_write(string req);
    logic [7:0] ewe; logic [63:0] ewd; logic [ADDR_W-1:0] ead;
    model(ewe, ewd, ead);
    wr_stb = 1;
    @(posedge clk); #2;
    chk({req, " we"}, mem_we, ewe);
    chk({req, " data"}, mem_wdata & byte_mask(ewe), ewd & byte_mask(ewe));
    chk({req, " addr"}, mem_addr, ead);
    @(negedge clk);
    wr_stb = 0;
  endtask

  task automatic do_read(logic [ADDR_W-1:0] a, logic [63:0] w);
    cpu_addr = a; mem_rdata = w; rd_stb = 1;
    #1 chk("R11 rd_addr", rd_addr, {a[ADDR_W-1:2], 2'b00});
    @(posedge clk); #2;
    chk("R11 rd_data", rd_data, w[a[1:0]*8 +: 8]);
    for (int i = 0; i < 8; i++) lt[i] = w[i*8 +: 8];
    @(negedge clk);
    rd_stb = 0;
    write_mode = 1; plane_mask = 8'hFF; latch8 = 1; ext_write = 0;
    do_write("R11 R5 latch via mode1");
  endtask

  task automatic rand_regs();
    cpu_addr = ADDR_W'($urandom); cpu_data = 8'($urandom);
    rot_fn = 5'($urandom); bit_mask = 8'($urandom);
    set_reset = 8'($urandom); sr_enable = 8'($urandom);
    plane_mask = 8'($urandom); ext_write = 1'($urandom);
    addr_by8 = 1'($urandom); latch8 = 1'($urandom);
    expand_by4 = 1'($urandom); fg_color = 8'($urandom); bg_color = 8'($urandom);
    decode_mask = ($urandom % 2) ? '1 : ADDR_W'($urandom);
  endtask

  initial begin
    #200000;
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 8; i++) lt[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 we", mem_we, 0); chk("R1 data", mem_wdata, 0);
    chk("R1 addr", mem_addr, 0); chk("R1 rd_data", rd_data, 0);
    rst_n = 1;
    @(negedge clk);
    write_mode = 1; plane_mask = 8'hFF; latch8 = 1;
    do_write("R1 latch zero");

    // directed: rotate, fast path
    do_read(20'h00123, 64'h8877665544332211);
    write_mode = 0; cpu_data = 8'h81; rot_fn = 5'b00_001; bit_mask = 8'hFF; sr_enable = 0;
    plane_mask = 8'h0F; latch8 = 0;
    do_write("R2 rotate by 1");
    rot_fn = 5'b11_011; bit_mask = 8'h3C;
    do_write("R3 xor partial mask");
    sr_enable = 8'h05; set_reset = 8'h04; rot_fn = 5'b00_000; bit_mask = 8'hFF;
    do_write("R4 set/reset");
    write_mode = 2; cpu_data = 8'h0A; rot_fn = 5'b01_000; bit_mask = 8'hF0;
    do_write("R4 mode2 and");
    write_mode = 3; cpu_data = 8'hF0; rot_fn = 5'b10_100; bit_mask = 8'h3C; set_reset = 8'hFF;
    do_write("R6 mode3 or");
    // R7 / R8 across modes
    plane_mask = 8'hE1; latch8 = 0; ext_write = 1; addr_by8 = 1;
    for (int m = 0; m < 4; m++) begin write_mode = 3'(m); do_write("R8 reversed"); end
    latch8 = 1; ext_write = 0;
    for (int m = 0; m < 4; m++) begin write_mode = 3'(m); do_write("R7 eight planes"); end
    latch8 = 0;
    do_write("R7 four planes");
    // R9 / R10 expansion
    cpu_addr = 20'hC0001; decode_mask = 20'h0FFFF; cpu_data = 8'hA5; plane_mask = 8'hF3;
    fg_color = 8'h3E; bg_color = 8'h71;
    write_mode = 4; expand_by4 = 1; do_write("R9 R10 mode4 by4");
    write_mode = 5; expand_by4 = 0; do_write("R9 R10 mode5 by2");
    // R12 bad modes
    write_mode = 6; do_write("R12 mode6");
    write_mode = 7; do_write("R12 mode7");
    @(posedge clk); #2 chk("R12 idle", mem_we, 0);
    @(negedge clk);

    for (int n = 0; n < 600; n++) begin
      rand_regs();
      if ($urandom % 8 == 0) do_read(ADDR_W'($urandom), {$urandom, $urandom});
      else begin
        write_mode = 3'($urandom % 8);
        do_write("R2 R3 R7 R8 R9 R10 random");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule